// File: doc/BRIEF.md
# Transfer Completion Interrupt and Chain Trigger Unit

This unit sits beside a DMA channel controller and turns completion notifications into software interrupts and follow-on channel triggers. Each notification carries the 32-bit option word of the parameter set that produced it, a flag that says whether the request was the last one of that set, and a flag that says which stage of the request is being reported: submission to the transfer engine, or the end of data movement. A 6-bit completion code inside the option word selects one of 64 channels.

Depending on four enable bits in the option word, the notification sets one bit in a 64-bit pending register (which, masked by a 64-bit enable input, drives a single CPU interrupt line) and/or fires a chain trigger for the channel named by the code. Interrupt and chaining are enabled independently for the last request and for the requests before it. An early-signalling bit in the option word moves the point of completion from the end of data movement to submission. Software clears pending bits through a write-1-to-clear input and can fire channel triggers directly through a manual event input. Every trigger leaves the unit as a one-cycle pulse.

Top module: `cmpl_irq_chain`

## Requirements
- R1: After reset the pending register is all zero, the interrupt line is low and no trigger bit is high.
- R2: Option bits 17:12 hold the completion code; an accepted notification sets at most one pending bit and at most one trigger bit, both at the index given by that code, visible on the outputs one clock after the notification is sampled.
- R3: A notification with the last flag high sets the pending bit only when option bit 20 is 1; option bit 21 has no effect on it.
- R4: A notification with the last flag low sets the pending bit only when option bit 21 is 1; option bit 20 has no effect on it.
- R5: A trigger pulse for the code's channel is produced when the last flag is high and option bit 22 is 1, or when the last flag is low and option bit 23 is 1; no other combination produces one.
- R6: With option bit 11 at 0 only notifications whose stage flag is 1 (data moved) are acted on; with option bit 11 at 1 only notifications whose stage flag is 0 (submitted) are acted on. The other stage has no effect on pending bits or triggers.
- R7: The interrupt line is high exactly when at least one pending bit has its enable bit at 1.
- R8: A 1 on a bit of the clear input clears that pending bit on the next clock; when a set and a clear hit the same bit in the same cycle, the bit ends up set. Pending bits otherwise hold.
- R9: A 1 on a bit of the manual event input produces a trigger pulse on that channel one clock later; manual and chained triggers of the same cycle are merged.
- R10: Every trigger bit is high for exactly one cycle unless a new chain or manual event for that channel arrives in the cycle it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ntf_valid | input | 1 | A completion notification is present this cycle |
| ntf_done | input | 1 | Stage: 1 = data moved, 0 = request submitted |
| ntf_last | input | 1 | 1 = last request of its parameter set |
| ntf_opt | input | 32 | Option word of the parameter set |
| irq_en | input | 64 | Per-channel interrupt enable mask |
| pend_clr | input | 64 | Write-1-to-clear for pending bits |
| evt_set | input | 64 | Manual event set, one bit per channel |
| pend | output | 64 | Interrupt pending register |
| trig | output | 64 | One-cycle trigger pulses per channel |
| cpu_irq | output | 1 | Interrupt to the CPU |

## Verification
The bench targets the swap of last versus intermediate enables: a design that reads bit 20 for intermediate requests would raise interrupts on every request and a bench entry with only bit 21 on a last request exposes it. It drives both stage flags with the early bit in each state, since a unit that ignores bit 11 would report completion twice or never. It hits the same bit with set and clear in one cycle, where a clear-priority design would lose an interrupt, and uses codes 0 and 63 to catch off-by-one code slicing. Trigger bits are watched on the following cycle so that a unit which latches instead of pulsing re-fires a channel.

// File: rtl/cmpl_pkg.sv
package cmpl_pkg;
  localparam int OPT_W       = 32;
  localparam int CODE_W      = 6;
  localparam int CODE_LSB    = 12;
  localparam int NCH         = 1 << CODE_W;
  localparam int BIT_EARLY   = 11;
  localparam int BIT_FIN_INT = 20;
  localparam int BIT_MID_INT = 21;
  localparam int BIT_FIN_CHN = 22;
  localparam int BIT_MID_CHN = 23;

  typedef struct packed {
    logic              early;
    logic              fin_int;
    logic              mid_int;
    logic              fin_chn;
    logic              mid_chn;
    logic [CODE_W-1:0] code;
  } opt_fields_t;

  function automatic opt_fields_t unpack_opt(input logic [OPT_W-1:0] w);
    opt_fields_t f;
    f.early   = w[BIT_EARLY];
    f.fin_int = w[BIT_FIN_INT];
    f.mid_int = w[BIT_MID_INT];
    f.fin_chn = w[BIT_FIN_CHN];
    f.mid_chn = w[BIT_MID_CHN];
    f.code    = w[CODE_LSB +: CODE_W];
    return f;
  endfunction
endpackage

// File: rtl/cmpl_decode.sv
module cmpl_decode
  import cmpl_pkg::*;
#(
  parameter int N = NCH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ntf_valid,
  input  logic             ntf_done,
  input  logic             ntf_last,
  input  logic [OPT_W-1:0] ntf_opt,
  output logic [N-1:0]     pend_set,
  output logic [N-1:0]     chain_set
);
  opt_fields_t fld;
  logic        take;
  logic        want_int;
  logic        want_chn;
  logic [N-1:0] hit;

  always_comb begin
    fld      = unpack_opt(ntf_opt);
    // normal mode reports at data-moved stage, early mode at submission
    take     = ntf_valid && (ntf_done != fld.early);
    want_int = ntf_last ? fld.fin_int : fld.mid_int;
    want_chn = ntf_last ? fld.fin_chn : fld.mid_chn;
    hit      = {{(N-1){1'b0}}, 1'b1} << fld.code;
    pend_set  = (take && want_int) ? hit : '0;
    chain_set = (take && want_chn) ? hit : '0;
  end

  // R2
  one_pend_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pend_set) && $onehot0(chain_set));
  // R6
  wrong_stage_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ntf_valid && (ntf_done == ntf_opt[BIT_EARLY])) |-> (pend_set == '0 && chain_set == '0));
endmodule

// File: rtl/cmpl_pend.sv
module cmpl_pend #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] pend_o,
  output logic         irq_o
);
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;
  logic         pend_ce;

  always_comb begin
    pend_ce = (|set_i) || (|clr_i);
    // set has priority over a simultaneous clear
    pend_d  = (pend_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_ce) pend_q <= pend_d;
  end

  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & en_i);

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i)));
  // R8
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((pend_q & $past(clr_i & ~set_i)) == '0));
  // R7
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend_q != '0));
endmodule

// File: rtl/cmpl_trig.sv
module cmpl_trig #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] chain_i,
  input  logic [N-1:0] manual_i,
  output logic [N-1:0] trig_o
);
  logic [N-1:0] evt_q;
  logic [N-1:0] evt_d;
  logic         evt_ce;

  always_comb begin
    evt_d  = chain_i | manual_i;
    // register only loads when something changes: new events or a pulse to retire
    evt_ce = (|evt_d) || (|evt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      evt_q <= '0;
    else if (evt_ce) evt_q <= evt_d;
  end

  assign trig_o = evt_q;

  // R10
  pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_q & ~chain_i & ~manual_i)) |=> ((evt_q & $past(evt_q & ~chain_i & ~manual_i)) == '0));
  // R9
  manual_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|manual_i) |=> ((evt_q & $past(manual_i)) == $past(manual_i)));
endmodule

// File: rtl/cmpl_irq_chain.sv
module cmpl_irq_chain
  import cmpl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ntf_valid,
  input  logic             ntf_done,
  input  logic             ntf_last,
  input  logic [OPT_W-1:0] ntf_opt,
  input  logic [NCH-1:0]   irq_en,
  input  logic [NCH-1:0]   pend_clr,
  input  logic [NCH-1:0]   evt_set,
  output logic [NCH-1:0]   pend,
  output logic [NCH-1:0]   trig,
  output logic             cpu_irq
);
  logic [NCH-1:0] pend_set;
  logic [NCH-1:0] chain_set;

  cmpl_decode #(.N(NCH)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .ntf_valid(ntf_valid), .ntf_done(ntf_done), .ntf_last(ntf_last), .ntf_opt(ntf_opt),
    .pend_set(pend_set), .chain_set(chain_set)
  );

  cmpl_pend #(.N(NCH)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .set_i(pend_set), .clr_i(pend_clr), .en_i(irq_en),
    .pend_o(pend), .irq_o(cpu_irq)
  );

  cmpl_trig #(.N(NCH)) u_trig (
    .clk(clk), .rst_n(rst_n),
    .chain_i(chain_set), .manual_i(evt_set), .trig_o(trig)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (pend == '0 && trig == '0 && !cpu_irq));
endmodule

// File: tb/sim_cmpl_irq_chain.sv
module sim_cmpl_irq_chain;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ntf_valid, ntf_done, ntf_last;
  logic [31:0] ntf_opt;
  logic [63:0] irq_en, pend_clr, evt_set;
  logic [63:0] pend, trig;
  logic        cpu_irq;

  int n_run = 0;
  int n_fail = 0;
  logic [63:0] pend_m = '0;
  logic [63:0] trig_m = '0;

  always #2.5 clk = ~clk;

  cmpl_irq_chain u0 (
    .clk(clk), .rst_n(rst_n), .ntf_valid(ntf_valid), .ntf_done(ntf_done),
    .ntf_last(ntf_last), .ntf_opt(ntf_opt), .irq_en(irq_en), .pend_clr(pend_clr),
    .evt_set(evt_set), .pend(pend), .trig(trig), .cpu_irq(cpu_irq)
  );

  function automatic logic [63:0] sel_bit(input logic v, input logic d, input logic l,
                                           input logic [31:0] o, input int fb, input int mb);
    if (v && (d != o[11]) && (l ? o[fb] : o[mb])) return 64'd1 << o[17:12];
    return '0;
  endfunction

  function automatic logic [31:0] mk_opt(input int code, input logic early,
                                          input logic fi, input logic mi,
                                          input logic fc, input logic mc);
    logic [31:0] o = '0;
    o[17:12] = code[5:0]; o[11] = early;
    o[20] = fi; o[21] = mi; o[22] = fc; o[23] = mc;
    return o;
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    ntf_valid = 0; ntf_done = 0; ntf_last = 0; ntf_opt = '0;
    pend_clr = '0; evt_set = '0;
  endtask

  // apply current inputs for one clock, update model, check at the following negedge
  task automatic cyc(input string tag);
    logic [63:0] ps, cs;
    ps = sel_bit(ntf_valid, ntf_done, ntf_last, ntf_opt, 20, 21);
    cs = sel_bit(ntf_valid, ntf_done, ntf_last, ntf_opt, 22, 23);
    pend_m = (pend_m & ~pend_clr) | ps;
    trig_m = cs | evt_set;
    @(posedge clk); @(negedge clk);
    chk(tag, "pend", pend, pend_m);
    chk(tag, "trig", trig, trig_m);
    chk(tag, "irq", {63'd0, cpu_irq}, {63'd0, |(pend_m & irq_en)});
    idle();
  endtask

  task automatic ntf(input logic d, input logic l, input logic [31:0] o);
    ntf_valid = 1; ntf_done = d; ntf_last = l; ntf_opt = o;
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; irq_en = '0; idle();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "pend", pend, '0);
    chk("R1", "trig", trig, '0);
    chk("R1", "irq", {63'd0, cpu_irq}, '0);
    rst_n = 1;
    irq_en = '1;
    // R3 final with bit20, normal mode, data moved
    ntf(1, 1, mk_opt(5, 0, 1, 0, 0, 0)); cyc("R3");
    // R3 final with only bit21: nothing
    ntf(1, 1, mk_opt(6, 0, 0, 1, 0, 0)); cyc("R3");
    // R4 intermediate with bit21, highest code
    ntf(1, 0, mk_opt(63, 0, 0, 1, 0, 0)); cyc("R4");
    // R4 intermediate with only bit20: nothing
    ntf(1, 0, mk_opt(7, 0, 1, 0, 0, 0)); cyc("R4");
    // R2 code zero
    ntf(1, 1, mk_opt(0, 0, 1, 0, 0, 0)); cyc("R2");
    // R6 early mode ignores data-moved stage, acts on submission
    ntf(1, 1, mk_opt(20, 1, 1, 0, 1, 0)); cyc("R6");
    ntf(0, 1, mk_opt(20, 1, 1, 0, 1, 0)); cyc("R6");
    // R6 normal mode ignores submission stage
    ntf(0, 1, mk_opt(21, 0, 1, 0, 1, 0)); cyc("R6");
    // R5 chain on final via bit22, then pulse must retire (R10)
    ntf(1, 1, mk_opt(9, 0, 0, 0, 1, 0)); cyc("R5");
    cyc("R10");
    // R5 chain on intermediate via bit23; bit22 alone on intermediate is inert
    ntf(1, 0, mk_opt(10, 0, 0, 0, 0, 1)); cyc("R5");
    ntf(1, 0, mk_opt(11, 0, 0, 0, 1, 0)); cyc("R5");
    // R9 manual event merged with a chain event
    evt_set = 64'h8000_0000_0000_0001; ntf(1, 1, mk_opt(12, 0, 0, 0, 1, 0)); cyc("R9");
    cyc("R10");
    // R8 set and clear on the same bit: set wins
    pend_clr = 64'd1 << 30; ntf(1, 1, mk_opt(30, 0, 1, 0, 0, 0)); cyc("R8");
    // R8 plain clear of bits 5 and 30
    pend_clr = (64'd1 << 5) | (64'd1 << 30); cyc("R8");
    // R7 mask out remaining pending bits
    irq_en = '0; cyc("R7");
    irq_en = 64'd1 << 63; cyc("R7");
    // random phase
    for (int k = 0; k < 3000; k++) begin
      ntf_valid = $urandom_range(0, 1);
      ntf_done  = $urandom_range(0, 1);
      ntf_last  = $urandom_range(0, 1);
      ntf_opt   = $urandom;
      pend_clr  = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      irq_en    = {$urandom, $urandom};
      evt_set   = ($urandom_range(0, 3) == 0) ? (64'd1 << $urandom_range(0, 63)) : '0;
      cyc("RND");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule